// File: doc/BRIEF.md
# Two-Channel Audio Mode Selector

This block turns a small parallel control port into switch settings for two audio output pairs: the main pair and the SCART pair. Three binary data lines carry a 3-bit mode code. A fourth line arrives already decoded to one of three levels: low, high or high-impedance. That level chooses which channel's mode register the data lines write. While it is high-impedance, both registers keep their contents, so a controller can set up the next code on the data lines without disturbing the outputs. The new code takes effect when the select line goes low (main) or high (SCART).

Each register is combined with two identification flags, stereo and dual, which come from an external pilot detector. The result is, per channel, a route code, a mute flag, a de-emphasis enable and a gain select. The block also drives two indicator outputs. Cross-channel rules apply:
- A muted main register locks the SCART register and silences everything.
- Forced mono is taken from the main register for both pairs.
- A mono selection is upgraded automatically when a stereo or dual transmission is identified.

Every control input first passes a two-stage synchronizer and a persistence filter. After reset, the block holds both channels muted for a programmable time. The control port carries no data stream, so there is no valid/ready handshake and no back-pressure. All pins are plain levels.

Top module: `audio_mode_ctrl`

## Requirements
- R1: With the filtered select at low (`chsel_lvl` = 2'b00), the main register takes the `data_lines` code. With the select at high (2'b01), the SCART register takes it, subject to R4 and R5.
- R2: With the select at high-impedance (2'b10, and 2'b11 is treated the same), both registers keep their values whatever the data lines do. A code prepared in this state is applied when the select moves to low or high.
- R3: After reset, both registers read mute (3'b000) and no load is taken for `POR_HOLD` cycles. Until then both channels report `mute`=1. After that, main follows the lines if the select is low.
- R4: While the main register holds 3'b000, the SCART register cannot be written.
- R5: Code 3'b000 presented with the select high is illegal and leaves the SCART register unchanged.
- R6: Main code 3'b000 is full mute. Both channels mute, the identification flags are ignored (no upgrade) and both indicators are off.
- R7: Code 3'b100 is sound mute for the channel that holds it. It mutes only that channel, and the indicators keep following the identification flags.
- R8: Codes 3'b001 and 3'b010 give a mono route (route 0) with de-emphasis on and gain high when no flag is active. Code 3'b011 (AM mono) gives route 0 with `deemph_en`=0 and `gain_hi`=0, and the flags never upgrade it.
- R9: In codes 001, 010, 101 and 110, an active stereo flag gives route 1 (stereo de-matrix) unless the main register holds 3'b101 (forced mono). The main register decides this for both pairs.
- R10: An active dual flag takes priority over stereo. It gives route 2 (A) for codes 001 and 101, route 3 (B) for 010, and route 4 (A left, B right) for 110, chosen per channel.
- R11: Code 3'b111 gives route 5 (external source). When the main register holds it, both indicators are off.
- R12: A change on any control line that lasts fewer than `FILT_LEN` clock cycles after synchronization is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| data_lines | input | 3 | Mode code lines, bit 0 first line |
| chsel_lvl | input | 2 | Decoded select level: 00 low, 01 high, 10/11 high-impedance |
| id_stereo | input | 1 | Stereo transmission identified |
| id_dual | input | 1 | Dual transmission identified |
| main_route | output | 3 | Main pair route code (0 mono, 1 stereo, 2 A, 3 B, 4 A/B, 5 external) |
| main_mute | output | 1 | Main pair muted |
| main_deemph_en | output | 1 | Main pair de-emphasis enabled |
| main_gain_hi | output | 1 | Main pair high gain selected |
| scart_route | output | 3 | SCART pair route code, same encoding |
| scart_mute | output | 1 | SCART pair muted |
| scart_deemph_en | output | 1 | SCART pair de-emphasis enabled |
| scart_gain_hi | output | 1 | SCART pair high gain selected |
| led_stereo | output | 1 | Stereo indicator drive |
| led_dual | output | 1 | Dual indicator drive |

## Verification
A register load and a change of the identification flags can land in the same cycle. An example is a main register moving into full mute or external mode while the dual flag rises. Whether the result shows the upgraded route or the gated one then depends on both events. The bench provokes this in its random phase, where each step changes the select level, the data code and both flags together. It judges the settled outputs of both channels and both indicators against a model that applies the register update first and then the flag rules. Directed steps cover the same mix on purpose: stereo active during full mute, and dual active when main enters external mode.

// File: rtl/amc_pkg.sv
package amc_pkg;

  localparam int MODE_W = 3;
  localparam int NUM_CH = 2;
  localparam int CH_MAIN  = 0;
  localparam int CH_SCART = 1;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_HIZ  = 2'b10,
    SEL_RSVD = 2'b11
  } sel_lvl_e;

  localparam logic [MODE_W-1:0] MD_MUTE    = 3'b000;
  localparam logic [MODE_W-1:0] MD_MONO_A  = 3'b001;
  localparam logic [MODE_W-1:0] MD_MONO_B  = 3'b010;
  localparam logic [MODE_W-1:0] MD_AM      = 3'b011;
  localparam logic [MODE_W-1:0] MD_SMUTE   = 3'b100;
  localparam logic [MODE_W-1:0] MD_FMONO   = 3'b101;
  localparam logic [MODE_W-1:0] MD_MONO_AB = 3'b110;
  localparam logic [MODE_W-1:0] MD_EXT     = 3'b111;

  typedef enum logic [2:0] {
    RT_MONO    = 3'd0,
    RT_STEREO  = 3'd1,
    RT_DUAL_A  = 3'd2,
    RT_DUAL_B  = 3'd3,
    RT_DUAL_AB = 3'd4,
    RT_EXT     = 3'd5
  } route_e;

  typedef struct packed {
    route_e route;
    logic   mute;
    logic   deemph_en;
    logic   gain_hi;
  } chan_ctl_t;

  localparam chan_ctl_t CTL_SILENT = '{route: RT_MONO, mute: 1'b1, deemph_en: 1'b1, gain_hi: 1'b1};

endpackage

// File: rtl/amc_line_filter.sv
module amc_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 4,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean   <= RST_VAL;
      run_cnt <= '0;
    end else if (synced == clean) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(FILT_LEN - 1)) begin
      clean   <= synced;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_STEADY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (synced == clean) |=> $stable(clean)); // R12
  AST_FRESH_DIFF_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (synced != clean && run_cnt == '0) |=> $stable(clean)); // R12

endmodule

// File: rtl/amc_mode_regs.sv
module amc_mode_regs
  import amc_pkg::*;
#(
  parameter int POR_HOLD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] code_in,
  input  sel_lvl_e          sel,
  output logic [MODE_W-1:0] main_q,
  output logic [MODE_W-1:0] scart_q
);
  localparam int PW = $clog2(POR_HOLD + 1);

  logic [PW-1:0] por_cnt;
  logic          por_busy;
  logic          load_main, load_scart;

  assign por_busy   = (por_cnt != PW'(POR_HOLD));
  assign load_main  = !por_busy && (sel == SEL_LOW);
  assign load_scart = !por_busy && (sel == SEL_HIGH) &&
                      (main_q != MD_MUTE) && (code_in != MD_MUTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        por_cnt <= '0;
    else if (por_busy) por_cnt <= por_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q  <= MD_MUTE;
      scart_q <= MD_MUTE;
    end else begin
      if (load_main)  main_q  <= code_in;
      if (load_scart) scart_q <= code_in;
    end
  end

  AST_POR_BOTH_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    por_busy |-> (main_q == MD_MUTE && scart_q == MD_MUTE)); // R3
  AST_HIZ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HIZ || sel == SEL_RSVD) |=> ($stable(main_q) && $stable(scart_q))); // R2
  AST_SCART_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == MD_MUTE) |=> $stable(scart_q)); // R4
  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HIGH && code_in == MD_MUTE) |=> $stable(scart_q)); // R5
  AST_LOW_SPARES_SCART: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_LOW) |=> $stable(scart_q)); // R1

endmodule

// File: rtl/amc_chan_decode.sv
module amc_chan_decode
  import amc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [MODE_W-1:0] main_mode,
  input  logic              id_st,
  input  logic              id_du,
  output chan_ctl_t         ctl_q
);
  chan_ctl_t nxt;
  logic      id_live, st_on, du_on, fmono_all;

  assign id_live   = (main_mode != MD_MUTE);
  assign st_on     = id_st && id_live;
  assign du_on     = id_du && id_live;
  assign fmono_all = (main_mode == MD_FMONO);

  always_comb begin
    nxt = CTL_SILENT;
    if (id_live) begin
      unique case (mode)
        MD_MUTE, MD_SMUTE: nxt = CTL_SILENT;
        MD_AM: nxt = '{route: RT_MONO, mute: 1'b0, deemph_en: 1'b0, gain_hi: 1'b0};
        MD_EXT: nxt = '{route: RT_EXT, mute: 1'b0, deemph_en: 1'b1, gain_hi: 1'b1};
        default: begin
          nxt.mute      = 1'b0;
          nxt.deemph_en = 1'b1;
          nxt.gain_hi   = 1'b1;
          if (du_on) begin
            if (mode == MD_MONO_B)       nxt.route = RT_DUAL_B;
            else if (mode == MD_MONO_AB) nxt.route = RT_DUAL_AB;
            else                         nxt.route = RT_DUAL_A;
          end else if (st_on && !fmono_all) begin
            nxt.route = RT_STEREO;
          end else begin
            nxt.route = RT_MONO;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_SILENT;
    else        ctl_q <= nxt;
  end

  AST_FULL_MUTE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (main_mode == MD_MUTE) |=> (ctl_q.mute && ctl_q.route == RT_MONO)); // R6
  AST_SMUTE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SMUTE) |=> ctl_q.mute); // R7
  AST_AM_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_AM && main_mode != MD_MUTE) |=>
      (!ctl_q.mute && !ctl_q.deemph_en && !ctl_q.gain_hi && ctl_q.route == RT_MONO)); // R8
  AST_FMONO_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
    (main_mode == MD_FMONO) |=> (ctl_q.route != RT_STEREO)); // R9
  AST_DUAL_BEATS_STEREO: assert property (@(posedge clk) disable iff (!rst_n)
    (id_du && id_st && main_mode != MD_MUTE) |=> (ctl_q.route != RT_STEREO)); // R10
  AST_EXT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_EXT && main_mode != MD_MUTE) |=> (ctl_q.route == RT_EXT && !ctl_q.mute)); // R11

endmodule

// File: rtl/audio_mode_ctrl.sv
module audio_mode_ctrl
  import amc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int POR_HOLD    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] data_lines,
  input  logic [1:0] chsel_lvl,
  input  logic       id_stereo,
  input  logic       id_dual,
  output logic [2:0] main_route,
  output logic       main_mute,
  output logic       main_deemph_en,
  output logic       main_gain_hi,
  output logic [2:0] scart_route,
  output logic       scart_mute,
  output logic       scart_deemph_en,
  output logic       scart_gain_hi,
  output logic       led_stereo,
  output logic       led_dual
);
  localparam int NLINES = MODE_W + 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic [MODE_W-1:0] main_q, scart_q;
  logic [NUM_CH-1:0][MODE_W-1:0] chan_mode;
  chan_ctl_t ctl [NUM_CH];
  sel_lvl_e  sel_f;
  logic      id_live;

  assign raw_lines = {chsel_lvl, data_lines};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    amc_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .RST_VAL    (1'b0)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[i]),
      .clean(clean_lines[i])
    );
  end

  assign sel_f = sel_lvl_e'(clean_lines[NLINES-1:MODE_W]);

  amc_mode_regs #(.POR_HOLD(POR_HOLD)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_in(clean_lines[MODE_W-1:0]),
    .sel    (sel_f),
    .main_q (main_q),
    .scart_q(scart_q)
  );

  assign chan_mode[CH_MAIN]  = main_q;
  assign chan_mode[CH_SCART] = scart_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    amc_chan_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (chan_mode[c]),
      .main_mode(main_q),
      .id_st    (id_stereo),
      .id_du    (id_dual),
      .ctl_q    (ctl[c])
    );
  end

  assign id_live = (main_q != MD_MUTE) && (main_q != MD_EXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_stereo <= 1'b0;
      led_dual   <= 1'b0;
    end else begin
      led_stereo <= id_stereo && id_live;
      led_dual   <= id_dual && id_live;
    end
  end

  assign main_route      = ctl[CH_MAIN].route;
  assign main_mute       = ctl[CH_MAIN].mute;
  assign main_deemph_en  = ctl[CH_MAIN].deemph_en;
  assign main_gain_hi    = ctl[CH_MAIN].gain_hi;
  assign scart_route     = ctl[CH_SCART].route;
  assign scart_mute      = ctl[CH_SCART].mute;
  assign scart_deemph_en = ctl[CH_SCART].deemph_en;
  assign scart_gain_hi   = ctl[CH_SCART].gain_hi;

  AST_LED_DARK_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == MD_EXT) |=> (!led_stereo && !led_dual)); // R11
  AST_LED_DARK_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == MD_MUTE) |=> (!led_stereo && !led_dual && main_mute && scart_mute)); // R6
  AST_LED_FOLLOWS_SMUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == MD_SMUTE) |=> (led_stereo == $past(id_stereo))); // R7

endmodule

// File: tb/audio_mode_ctrl_bench.sv
`timescale 1ns/1ps
module audio_mode_ctrl_bench;
  localparam int FILT_LEN = 4;
  localparam int POR_HOLD = 64;
  localparam int SETTLE   = 20;
  localparam logic [1:0] LOW = 2'b00, HIGH = 2'b01, HIZ = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] data_lines = 3'b001;
  logic [1:0] chsel_lvl = LOW;
  logic id_stereo = 1'b0, id_dual = 1'b0;
  logic [2:0] main_route, scart_route;
  logic main_mute, main_deemph_en, main_gain_hi;
  logic scart_mute, scart_deemph_en, scart_gain_hi;
  logic led_stereo, led_dual;

  int n_checks = 0;
  int n_fail = 0;
  logic [2:0] m_main = 3'b000, m_scart = 3'b000;

  always #5 clk = ~clk;

  audio_mode_ctrl #(.FILT_LEN(FILT_LEN), .POR_HOLD(POR_HOLD)) u_audio_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .data_lines(data_lines), .chsel_lvl(chsel_lvl),
    .id_stereo(id_stereo), .id_dual(id_dual),
    .main_route(main_route), .main_mute(main_mute),
    .main_deemph_en(main_deemph_en), .main_gain_hi(main_gain_hi),
    .scart_route(scart_route), .scart_mute(scart_mute),
    .scart_deemph_en(scart_deemph_en), .scart_gain_hi(scart_gain_hi),
    .led_stereo(led_stereo), .led_dual(led_dual)
  );

  // {route, mute, deemph, gain} for one channel, from the requirements
  function automatic logic [5:0] exp_chan(logic [2:0] m, logic [2:0] mm, logic st, logic du);
    logic [2:0] r;
    if (mm == 3'b000 || m == 3'b000 || m == 3'b100) return {3'd0, 3'b111};
    case (m)
      3'b011: return {3'd0, 3'b000};
      3'b111: return {3'd5, 3'b011};
      default: begin
        if (du) r = (m == 3'b010) ? 3'd3 : (m == 3'b110) ? 3'd4 : 3'd2;
        else if (st && mm != 3'b101) r = 3'd1;
        else r = 3'd0;
        return {r, 3'b011};
      end
    endcase
  endfunction

  function automatic logic [13:0] exp_all();
    logic lit;
    lit = (m_main != 3'b000) && (m_main != 3'b111);
    return {exp_chan(m_main, m_main, id_stereo, id_dual),
            exp_chan(m_scart, m_main, id_stereo, id_dual),
            id_stereo && lit, id_dual && lit};
  endfunction

  function automatic logic [13:0] act_all();
    return {main_route, main_mute, main_deemph_en, main_gain_hi,
            scart_route, scart_mute, scart_deemph_en, scart_gain_hi,
            led_stereo, led_dual};
  endfunction

  task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] sel, logic [2:0] code, logic st, logic du);
    @(negedge clk);
    chsel_lvl = sel; data_lines = code; id_stereo = st; id_dual = du;
    if (sel == LOW) m_main = code;
    else if (sel == HIGH && m_main != 3'b000 && code != 3'b000) m_scart = code;
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    #(10 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check("R3 reset state", act_all(), {3'd0, 3'b111, 3'd0, 3'b111, 2'b00});
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R3 hold keeps mute", act_all(), {3'd0, 3'b111, 3'd0, 3'b111, 2'b00});
    repeat (POR_HOLD + SETTLE) @(negedge clk);
    m_main = 3'b001;
    check("R3 main follows after hold", act_all(), exp_all());
    check("R8 mono path", act_all(), {3'd0, 3'b011, 3'd0, 3'b111, 2'b00});

    drive(LOW, 3'b000, 1'b1, 1'b0);
    check("R6 full mute ids ignored", act_all(), {3'd0, 3'b111, 3'd0, 3'b111, 2'b00});
    drive(HIGH, 3'b010, 1'b1, 1'b0);
    check("R4 scart locked", act_all(), exp_all());

    drive(LOW, 3'b100, 1'b1, 1'b0);
    check("R7 sound mute leds follow", act_all(), {3'd0, 3'b111, 3'd0, 3'b111, 2'b10});
    drive(HIGH, 3'b001, 1'b1, 1'b0);
    check("R9 scart stereo upgrade", act_all(), {3'd0, 3'b111, 3'd1, 3'b011, 2'b10});

    drive(HIGH, 3'b000, 1'b1, 1'b0);
    check("R5 illegal code ignored", act_all(), {3'd0, 3'b111, 3'd1, 3'b011, 2'b10});

    drive(HIZ, 3'b110, 1'b1, 1'b0);
    check("R2 hiz hold", act_all(), {3'd0, 3'b111, 3'd1, 3'b011, 2'b10});
    drive(HIZ, 3'b011, 1'b1, 1'b0);
    drive(LOW, 3'b011, 1'b1, 1'b0);
    check("R8 AM mono no upgrade", act_all(), {3'd0, 3'b000, 3'd1, 3'b011, 2'b10});

    drive(LOW, 3'b101, 1'b1, 1'b0);
    check("R9 forced mono common", act_all(), {3'd0, 3'b011, 3'd0, 3'b011, 2'b10});

    drive(LOW, 3'b101, 1'b1, 1'b1);
    check("R10 dual A priority", act_all(), exp_all());
    drive(HIGH, 3'b110, 1'b1, 1'b1);
    check("R10 scart dual AB", act_all(), {3'd2, 3'b011, 3'd4, 3'b011, 2'b11});
    drive(LOW, 3'b010, 1'b0, 1'b1);
    check("R10 main dual B", act_all(), {3'd3, 3'b011, 3'd4, 3'b011, 2'b01});

    drive(LOW, 3'b111, 1'b1, 1'b1);
    check("R11 external leds off", act_all(), {3'd5, 3'b011, 3'd4, 3'b011, 2'b00});

    @(negedge clk);
    data_lines = 3'b001;
    repeat (2) @(negedge clk);
    data_lines = 3'b111;
    repeat (SETTLE) @(negedge clk);
    check("R12 short glitch ignored", act_all(), exp_all());

    for (int it = 0; it < 200; it++) begin
      logic [1:0] s;
      case ($urandom % 4)
        0: s = LOW;
        1, 3: s = HIGH;
        default: s = HIZ;
      endcase
      drive(s, 3'($urandom), 1'($urandom), 1'($urandom));
      check("R1 random step", act_all(), exp_all());
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule